// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of an SDRAM read or write burst. A one-cycle start pulse loads a 9-bit start column, a burst length code and a burst type bit. From the next clock onward, the block presents one column per cycle with a valid flag. It stops when the programmed number of beats has been issued, when a stop pulse arrives, or when a new start pulse replaces the running burst.

Fixed-length bursts of 1, 2, 4 or 8 beats run in one of two orders. In sequential order the low bits count up and wrap inside the block aligned to the burst length. In interleave order each beat's column is the start column XORed with the beat index. Full-page mode is available only in sequential order. It walks through all 512 columns, wrapping from 511 to 0, and continues until it is stopped or replaced. A last-beat flag marks the final beat of a fixed-length burst. Bursts can be issued back to back one clock apart, and a new command may cut into a burst on any cycle.

Top module: `sdram_col_burst_gen`

## Requirements
- R1: In the cycle after `start_i` is sampled high, `valid_o` is 1 and `col_o` equals the sampled `start_col_i`, whatever the length code and type.
- R2: Length codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. `valid_o` stays high for exactly that many consecutive cycles, then drops, unless the burst is interrupted.
- R3: In sequential order (`ilv_i`=0), beat k of a length-N burst keeps the column bits above log2(N) equal to those of the start column. Its low log2(N) bits are (start + k) mod N.
- R4: In interleave order (`ilv_i`=1), beat k of a length-N burst has column start XOR k.
- R5: Length code 7 with `ilv_i`=0 selects full page. Beat k has column (start + k) mod 512, wrapping from 511 to 0, and the burst continues with no end of its own.
- R6: `last_o` is 1 exactly on the final beat of a fixed-length burst. It is never 1 in full-page mode and never 1 while `valid_o` is 0.
- R7: A `stop_i` sampled high during a burst (without `start_i`) makes `valid_o` 0 in the next cycle. A `stop_i` while idle has no effect: outputs stay idle.
- R8: A `start_i` sampled during a running burst abandons that burst at once, and the next cycle shows beat 0 of the new burst. `start_i` wins over a simultaneous `stop_i`. Starts may be issued on consecutive cycles.
- R9: Length codes 4, 5 and 6, and code 7 combined with `ilv_i`=1, are treated as single-beat bursts.
- R10: While in reset, and whenever `valid_o` is 0, `col_o` is 0 and `last_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Read/write command pulse: load a new burst |
| start_col_i | input | 9 | Starting column of the new burst |
| len_code_i | input | 3 | Burst length code (0..3 = 1..8 beats, 7 = full page) |
| ilv_i | input | 1 | Burst order: 0 sequential, 1 interleave |
| stop_i | input | 1 | Burst-terminate pulse |
| col_o | output | 9 | Column address of the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | Current beat is the final one of a fixed-length burst |

## Verification
The bench uses start columns in the middle of their aligned block. A design that counts across the block boundary in sequential order, or that adds rather than XORs in interleave order, then produces visibly wrong beats. A full-page burst is started close to column 511, so a missing wrap, or a burst that ends itself after some fixed count, shows up as a mismatch. Stops, replacing starts and start-with-stop collisions are placed mid-burst and on consecutive cycles. These expose a generator that lets the old burst finish, or that gives the stop priority. Reserved length codes, and full page requested with interleave, are checked to end after one beat.

// File: rtl/col_burst_pkg.sv
package col_burst_pkg;
  localparam int COL_W      = 9;
  localparam int LEN_CODE_W = 3;
  localparam int MAX_LOG    = 3;
  localparam logic [LEN_CODE_W-1:0] FULL_CODE = 3'd7;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode #(
  parameter int COL_W      = col_burst_pkg::COL_W,
  parameter int LEN_CODE_W = col_burst_pkg::LEN_CODE_W,
  parameter int MAX_LOG    = col_burst_pkg::MAX_LOG,
  parameter logic [LEN_CODE_W-1:0] FULL_CODE = col_burst_pkg::FULL_CODE
) (
  input  logic [LEN_CODE_W-1:0] code_i,
  input  logic                  ilv_i,
  output logic [COL_W-1:0]      mask_o,
  output logic                  full_o
);
  localparam int CODE_MAX = MAX_LOG;

  logic fixed_ok;
  assign fixed_ok = (int'(code_i) <= CODE_MAX);
  assign full_o   = (code_i == FULL_CODE) && !ilv_i;

  // mask = burst length - 1; reserved codes collapse to one beat
  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    assign mask_o[i] = full_o || (fixed_ok && (i < int'(code_i)));
  end
endmodule

// File: rtl/burst_col_calc.sv
module burst_col_calc #(
  parameter int COL_W = col_burst_pkg::COL_W
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] idx_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] seq_col, ilv_col, sum;

  assign sum     = base_i + idx_i;
  assign seq_col = (base_i & ~mask_i) | (sum & mask_i);
  assign ilv_col = base_i ^ (idx_i & mask_i);
  assign col_o   = ilv_i ? ilv_col : seq_col;
endmodule

// File: rtl/sdram_col_burst_gen.sv
module sdram_col_burst_gen #(
  parameter int COL_W      = col_burst_pkg::COL_W,
  parameter int LEN_CODE_W = col_burst_pkg::LEN_CODE_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [COL_W-1:0]      start_col_i,
  input  logic [LEN_CODE_W-1:0] len_code_i,
  input  logic                  ilv_i,
  input  logic                  stop_i,
  output logic [COL_W-1:0]      col_o,
  output logic                  valid_o,
  output logic                  last_o
);
  logic             active_q, ilv_q, full_q;
  logic [COL_W-1:0] base_q, idx_q, mask_q;
  logic [COL_W-1:0] dec_mask, calc_col;
  logic             dec_full, last_w;

  burst_len_decode #(.COL_W(COL_W), .LEN_CODE_W(LEN_CODE_W)) u_dec (
    .code_i (len_code_i),
    .ilv_i  (ilv_i),
    .mask_o (dec_mask),
    .full_o (dec_full)
  );

  burst_col_calc #(.COL_W(COL_W)) u_calc (
    .base_i (base_q),
    .idx_i  (idx_q),
    .mask_i (mask_q),
    .ilv_i  (ilv_q),
    .col_o  (calc_col)
  );

  assign last_w = active_q && !full_q && (idx_q == mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      ilv_q    <= 1'b0;
      full_q   <= 1'b0;
      base_q   <= '0;
      idx_q    <= '0;
      mask_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      ilv_q    <= ilv_i;
      full_q   <= dec_full;
      base_q   <= start_col_i;
      idx_q    <= '0;
      mask_q   <= dec_mask;
    end else if (stop_i) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      if (last_w) active_q <= 1'b0;
      else        idx_q    <= idx_q + 1'b1;  // full page wraps at 2**COL_W
    end
  end

  assign valid_o = active_q;
  assign last_o  = last_w;
  assign col_o   = active_q ? calc_col : '0;

  AST_START_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (valid_o && col_o == $past(start_col_i))); // R1
  AST_LAST_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !start_i) |=> !valid_o); // R2
  AST_UPPER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o && !start_i && !stop_i && !ilv_q)
      |=> ((col_o & ~$past(mask_q)) == ($past(col_o) & ~$past(mask_q)))); // R3
  AST_LAST_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o); // R6
  AST_STOP_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> !valid_o); // R7
endmodule

// File: tb/sim_sdram_col_burst_gen.sv
`timescale 1ns/1ps
module sim_sdram_col_burst_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, ilv_i = 1'b0, stop_i = 1'b0;
  logic [8:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic [8:0] col_o;
  logic       valid_o, last_o;

  int checks = 0, errors = 0, cycles = 0;
  string phase = "R10";

  // reference model state
  int m_active = 0, m_start = 0, m_k = 0, m_len = 1, m_full = 0, m_ilv = 0;

  always #2.5 clk = ~clk;

  sdram_col_burst_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .ilv_i(ilv_i), .stop_i(stop_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_active = 0; m_k = 0;
    end else if (start_i) begin
      m_active = 1; m_k = 0; m_start = int'(start_col_i); m_ilv = int'(ilv_i);
      m_full = 0;
      if (len_code_i <= 3) m_len = 1 << len_code_i;
      else if (len_code_i == 7 && !ilv_i) begin m_len = 512; m_full = 1; end
      else m_len = 1;
    end else if (stop_i) begin
      m_active = 0;
    end else if (m_active != 0) begin
      if (m_full == 0 && m_k == m_len - 1) m_active = 0;
      else m_k = (m_k + 1) % 512;
    end
  end

  function automatic int exp_col();
    if (m_active == 0) return 0;
    if (m_ilv != 0) return m_start ^ m_k;
    if (m_full != 0) return (m_start + m_k) % 512;
    return (m_start / m_len) * m_len + ((m_start + m_k) % m_len);
  endfunction

  task automatic chk(input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", phase, what, act, expv, $time);
    end
  endtask

  task automatic compare_all();
    chk("valid", int'(valid_o), m_active);
    chk("last", int'(last_o), (m_active != 0 && m_full == 0 && m_k == m_len - 1) ? 1 : 0);
    chk("col", int'(col_o), exp_col());
  endtask

  task automatic cyc(input logic s, input int c, input int code, input logic il, input logic st);
    @(negedge clk);
    compare_all();
    start_i = s; start_col_i = 9'(c); len_code_i = 3'(code); ilv_i = il; stop_i = st;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 0, 0, 1'b0, 1'b0);
  endtask

  task automatic burst(input int c, input int code, input logic il, input int n);
    cyc(1'b1, c, code, il, 1'b0);
    idle(n);
  endtask

  initial begin
    phase = "R10";
    idle(3);                       // reset state while rst_n low
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    phase = "R3"; burst(13, 3, 1'b0, 10);   // 13,14,15,8..12
    phase = "R3"; burst(6, 2, 1'b0, 6);     // 6,7,4,5
    phase = "R2";
    for (int code = 0; code < 4; code++) burst(37 + code, code, 1'b0, 10);
    phase = "R1"; burst(300, 3, 1'b1, 10);
    phase = "R4"; burst(6, 2, 1'b1, 6);     // 6,7,4,5
    phase = "R4"; burst(5, 3, 1'b1, 10);    // 5,4,7,6,1,0,3,2
    phase = "R4"; burst(258, 1, 1'b1, 4);

    phase = "R5"; burst(508, 7, 1'b0, 12);  // wraps 511 -> 0
    phase = "R7"; cyc(1'b0, 0, 0, 1'b0, 1'b1); idle(3);
    phase = "R5"; burst(0, 7, 1'b0, 600);   // runs past a full page
    phase = "R7"; cyc(1'b0, 0, 0, 1'b0, 1'b1); idle(2);
    phase = "R7";                            // stop while idle
    cyc(1'b0, 0, 0, 1'b0, 1'b1); cyc(1'b0, 0, 0, 1'b0, 1'b1); idle(2);
    phase = "R7"; burst(100, 3, 1'b0, 3); cyc(1'b0, 0, 0, 1'b0, 1'b1); idle(3);

    phase = "R8";
    burst(20, 3, 1'b0, 3);
    burst(77, 2, 1'b1, 2);                  // replace mid-burst
    cyc(1'b1, 200, 1, 1'b0, 1'b1);          // start beats simultaneous stop
    idle(4);
    for (int i = 0; i < 6; i++) cyc(1'b1, 10 * i + 3, i % 4, i[0], 1'b0);
    idle(10);
    burst(510, 7, 1'b0, 4);
    burst(9, 0, 1'b0, 3);                   // full page replaced

    phase = "R9";
    for (int code = 4; code < 7; code++) burst(45, code, 1'b0, 3);
    burst(45, 7, 1'b1, 3);

    phase = "R6"; burst(511, 3, 1'b0, 10); burst(64, 0, 1'b1, 3);

    idle(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule